// File: doc/BRIEF.md
# Serial SRAM Slave over SPI

This block is a serial static memory that answers as a slave on a four-wire SPI link in mode 0: clock idle low, master data sampled on the rising clock edge, slave data changed on the falling edge. The master lowers chip select and sends a one-byte opcode. For memory access the opcode is followed by a 24-bit address, sent most significant byte first, and then by data bytes, which flow in or out for as long as chip select stays low. A one-byte mode register controls how the internal address moves after each data byte. In byte mode there is a single transfer per selection. In page mode the address walks through a 32-byte page and folds back to the start of that page. In sequential mode the address walks through the whole array and folds back to zero.

The link pins are oversampled by a fast system clock through a short synchronizer. All state is therefore in one clock domain, and the SPI clock must run well below the system clock: each half period of the SPI clock should last at least four system clocks. The array depth is a parameter so the memory can be kept small. Only the low address bits that the depth needs are used, and the upper bits of the 24-bit address are ignored. The opcodes that would switch the link to two- or four-wire data are accepted and then ignored.

Top module: `sram_spi_slave`

## Requirements
- R1: Opcode 0x02 followed by three address bytes (most significant first) stores every following full data byte in the array. Only the low log2(DEPTH) address bits are used, so addresses that differ only above those bits reach the same location.
- R2: Opcode 0x03 followed by three address bytes returns the stored bytes on `miso`, most significant bit first. The first bit is driven after the falling `sck` edge that follows the last address bit, and each later bit changes on a falling edge.
- R3: Opcode 0x01 loads the next byte into the mode register, and opcode 0x05 returns the mode register as the next byte on `miso`. The mode register is 0x40 after reset.
- R4: Mode register bits [7:6] select the addressing: 00 is byte mode, 01 is sequential, 10 is page mode, and 11 behaves as byte mode.
- R5: In byte mode only one data byte is transferred per selection. Later written bytes are discarded, and later read bytes come back as 0x00.
- R6: In page mode the address steps by one after each data byte. From the last location of a 32-byte page it returns to the first location of the same page.
- R7: In sequential mode the address steps by one after each data byte and returns to zero after location DEPTH-1.
- R8: Raising `cs_n` discards any partly received byte, so a data byte is written only once all 8 bits have arrived, and the next selection starts with a fresh opcode.
- R9: Opcodes 0x3B, 0x38, 0xFF and every other opcode not listed above have no effect. The array and mode register are left untouched, and `miso` stays 0 for the rest of that selection.
- R10: `miso` is 0 after reset and while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the link |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | SPI clock from the master, idle low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, 0 when not selected |

## Verification
The hardest cases to reach from the pins are a data byte that is cut off by chip select after only a few bits, and an opcode that is cut off the same way. The bench drives a write that ends five bits into its second data byte, and a selection that carries only three opcode bits. It then reads the neighbouring locations and the mode register to show that neither the memory nor the decoder kept anything from the broken byte. The page and array wrap points are reached by writing across location 0x3F in page mode and across DEPTH-1 in sequential mode. Reads are then started on both sides of each boundary.

// File: rtl/sram_spi_pkg.sv
package sram_spi_pkg;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_MWR,
    ST_MRD,
    ST_SKIP
  } sram_state_e;

  // decoded from mode register bits [7:6]
  typedef enum logic [1:0] {
    AM_BYTE = 2'b00,
    AM_SEQ  = 2'b01,
    AM_PAGE = 2'b10,
    AM_RSVD = 2'b11
  } addr_mode_e;

  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_WRITE   = 8'h02;
  localparam logic [7:0] OP_MODE_RD = 8'h05;
  localparam logic [7:0] OP_MODE_WR = 8'h01;
  localparam logic [7:0] MODE_RESET = 8'h40;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic sel,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);

  logic [SYNC_STAGES-1:0] cs_q, sck_q, mosi_q;
  logic [SYNC_STAGES-1:0] cs_d, sck_d, mosi_d;
  logic                   sck_prev_q;

  always_comb begin
    cs_d   = {cs_q[SYNC_STAGES-2:0], cs_n};
    sck_d  = {sck_q[SYNC_STAGES-2:0], sck};
    mosi_d = {mosi_q[SYNC_STAGES-2:0], mosi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q       <= '1;
      sck_q      <= '0;
      mosi_q     <= '0;
      sck_prev_q <= 1'b0;
    end else begin
      cs_q       <= cs_d;
      sck_q      <= sck_d;
      mosi_q     <= mosi_d;
      sck_prev_q <= sck_q[SYNC_STAGES-1];
    end
  end

  assign sel      = ~cs_q[SYNC_STAGES-1];
  assign mosi_s   = mosi_q[SYNC_STAGES-1];
  assign sck_rise = sel &  sck_q[SYNC_STAGES-1] & ~sck_prev_q;
  assign sck_fall = sel & ~sck_q[SYNC_STAGES-1] &  sck_prev_q;

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       mosi_s,
  input  logic       tx_load,
  input  logic [7:0] tx_data,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       miso
);

  logic [2:0] bit_cnt_q, bit_cnt_d;
  logic [6:0] rx_q, rx_d;
  logic [7:0] tx_q, tx_d;
  logic       pend_q, pend_d;

  always_comb begin
    bit_cnt_d = bit_cnt_q;
    rx_d      = rx_q;
    tx_d      = tx_q;
    pend_d    = pend_q;
    if (!sel) begin
      bit_cnt_d = 3'd0;
      tx_d      = 8'h00;
      pend_d    = 1'b0;
    end else begin
      if (sck_rise) begin
        rx_d      = {rx_q[5:0], mosi_s};
        bit_cnt_d = bit_cnt_q + 3'd1;
      end
      if (tx_load) begin
        pend_d = 1'b1;
      end
      if (sck_fall) begin
        if (pend_q) begin
          tx_d   = tx_data;
          pend_d = 1'b0;
        end else begin
          tx_d = {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= 3'd0;
      rx_q      <= 7'd0;
      tx_q      <= 8'h00;
      pend_q    <= 1'b0;
    end else begin
      bit_cnt_q <= bit_cnt_d;
      rx_q      <= rx_d;
      tx_q      <= tx_d;
      pend_q    <= pend_d;
    end
  end

  assign byte_done = sel & sck_rise & (bit_cnt_q == 3'd7);
  assign rx_byte   = {rx_q, mosi_s};
  assign miso      = tx_q[7];

  // R8: deselection throws away a partial byte and any pending load
  a_r8_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (bit_cnt_q == 3'd0) && !pend_q);

  // R10: output is quiet once chip select has been seen high
  a_r10_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !miso);

  // R2: a pending load is consumed by the next falling edge
  a_r2_load_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    sel && sck_fall && pend_q |=> !pend_q || tx_load);

endmodule

// File: rtl/sram_cmd_fsm.sv
module sram_cmd_fsm
  import sram_spi_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  output logic              wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        wr_data,
  output logic              tx_load,
  output logic              tx_from_mode,
  output logic [7:0]        mode_reg
);

  localparam logic [ADDR_W-1:0] PMASK = ADDR_W'(PAGE_BYTES - 1);

  sram_state_e       st_q, st_d;
  logic              rd_q, rd_d;
  logic [1:0]        acnt_q, acnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_adv, addr_inc;
  logic [7:0]        mode_q, mode_d;
  addr_mode_e        amode;
  logic              single;

  assign amode  = addr_mode_e'(mode_q[7:6]);
  assign single = (amode == AM_BYTE) || (amode == AM_RSVD);

  // address step after a data byte, per addressing mode
  always_comb begin
    addr_inc = addr_q + ADDR_W'(1);
    case (amode)
      AM_SEQ:  addr_adv = addr_inc;
      AM_PAGE: addr_adv = (addr_q & ~PMASK) | (addr_inc & PMASK);
      default: addr_adv = addr_q;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    rd_d    = rd_q;
    acnt_d  = acnt_q;
    addr_d  = addr_q;
    mode_d  = mode_q;
    wr_en   = 1'b0;
    tx_load = 1'b0;
    if (!sel) begin
      st_d   = ST_CMD;
      acnt_d = 2'd0;
    end else if (byte_done) begin
      case (st_q)
        ST_CMD: begin
          acnt_d = 2'd0;
          case (rx_byte)
            OP_READ:    begin rd_d = 1'b1; st_d = ST_ADDR; end
            OP_WRITE:   begin rd_d = 1'b0; st_d = ST_ADDR; end
            OP_MODE_RD: begin st_d = ST_MRD; tx_load = 1'b1; end
            OP_MODE_WR: st_d = ST_MWR;
            default:    st_d = ST_SKIP;
          endcase
        end
        ST_ADDR: begin
          addr_d = ADDR_W'({addr_q, rx_byte});
          acnt_d = acnt_q + 2'd1;
          if (acnt_q == 2'd2) begin
            st_d    = rd_q ? ST_RDATA : ST_WDATA;
            tx_load = rd_q;
          end
        end
        ST_WDATA: begin
          wr_en = 1'b1;
          if (single) st_d = ST_SKIP;
          else        addr_d = addr_adv;
        end
        ST_RDATA: begin
          if (single) begin
            st_d = ST_SKIP;
          end else begin
            addr_d  = addr_adv;
            tx_load = 1'b1;
          end
        end
        ST_MWR: begin
          mode_d = rx_byte;
          st_d   = ST_SKIP;
        end
        default: st_d = ST_SKIP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_CMD;
      rd_q   <= 1'b0;
      acnt_q <= 2'd0;
      addr_q <= '0;
      mode_q <= MODE_RESET;
    end else begin
      st_q   <= st_d;
      rd_q   <= rd_d;
      acnt_q <= acnt_d;
      addr_q <= addr_d;
      mode_q <= mode_d;
    end
  end

  assign mem_addr     = addr_q;
  assign wr_data      = rx_byte;
  assign tx_from_mode = (st_q == ST_MRD);
  assign mode_reg     = mode_q;

  // R5: one data byte per selection in byte mode
  a_r5_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && (st_q == ST_WDATA || st_q == ST_RDATA) && (mode_q[7] == mode_q[6])
    |=> st_q == ST_SKIP);

  // R6: page mode folds back to the page start
  a_r6_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && (st_q == ST_WDATA || st_q == ST_RDATA) && (mode_q[7:6] == 2'b10)
      && ((addr_q & PMASK) == PMASK)
    |=> ((addr_q & PMASK) == '0) && ((addr_q & ~PMASK) == ($past(addr_q) & ~PMASK)));

  // R7: sequential mode folds the whole array back to zero
  a_r7_seq_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && (st_q == ST_WDATA || st_q == ST_RDATA) && (mode_q[7:6] == 2'b01)
      && (addr_q == '1)
    |=> addr_q == '0);

  // R9: an ignored opcode keeps the decoder parked for the selection
  a_r9_skip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sel && st_q == ST_SKIP |=> st_q == ST_SKIP);

  // R3: the mode register changes only on the byte after the mode-write opcode
  a_r3_mode_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_done && st_q == ST_MWR) |=> $stable(mode_q));

endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_data;
  end

  assign rd_data = mem[addr];

endmodule

// File: rtl/sram_spi_slave.sv
module sram_spi_slave #(
  parameter int DEPTH       = 256,
  parameter int PAGE_BYTES  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);

  localparam int ADDR_W = $clog2(DEPTH);

  logic              sel, sck_rise, sck_fall, mosi_s;
  logic              byte_done, tx_load, tx_from_mode, wr_en;
  logic [7:0]        rx_byte, tx_data, rd_data, wr_data, mode_reg;
  logic [ADDR_W-1:0] mem_addr;

  spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .sel(sel), .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
  );

  spi_byte_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi_s(mosi_s), .tx_load(tx_load),
    .tx_data(tx_data), .byte_done(byte_done), .rx_byte(rx_byte), .miso(miso)
  );

  sram_cmd_fsm #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sel(sel), .byte_done(byte_done),
    .rx_byte(rx_byte), .wr_en(wr_en), .mem_addr(mem_addr), .wr_data(wr_data),
    .tx_load(tx_load), .tx_from_mode(tx_from_mode), .mode_reg(mode_reg)
  );

  sram_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .addr(mem_addr), .wr_data(wr_data),
    .rd_data(rd_data)
  );

  assign tx_data = tx_from_mode ? mode_reg : rd_data;

endmodule

// File: tb/sram_spi_slave_test.sv
module sram_spi_slave_test;

  localparam int H = 6;  // system clocks per SPI half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string      tag_q[$];
  event       got_ev;

  always #5 clk = ~clk;

  sram_spi_slave uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] expv);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s got=%02h expected=%02h", tag, got, expv);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(got_ev);
      while (got_q.size() > 0) begin
        check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
      end
    end
  end

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int nbits);
    rx = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[7-i];
      wait_clk(H);
      rx = {rx[6:0], miso};
      sck = 1'b1;
      wait_clk(H);
      sck = 1'b0;
    end
  endtask

  task automatic put(input logic [7:0] tx);
    logic [7:0] rx;
    xfer(tx, rx, 8);
  endtask

  task automatic expect_byte(input logic [7:0] expv, input string tag);
    logic [7:0] rx;
    xfer(8'h00, rx, 8);
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    got_q.push_back(rx);
    -> got_ev;
  endtask

  task automatic sel_on;
    cs_n = 1'b0;
    wait_clk(H);
  endtask

  task automatic sel_off;
    wait_clk(H);
    cs_n = 1'b1;
    wait_clk(2 * H);
  endtask

  task automatic send_addr(input logic [23:0] a);
    put(a[23:16]);
    put(a[15:8]);
    put(a[7:0]);
  endtask

  // data holds up to four bytes, first byte in bits [31:24]
  task automatic mem_write(input logic [23:0] a, input logic [31:0] data, input int n);
    sel_on;
    put(8'h02);
    send_addr(a);
    for (int i = 0; i < n; i++) put(data[31-8*i -: 8]);
    sel_off;
  endtask

  task automatic mem_read(input logic [23:0] a, input logic [31:0] data, input int n,
                          input string tag);
    sel_on;
    put(8'h03);
    send_addr(a);
    for (int i = 0; i < n; i++) expect_byte(data[31-8*i -: 8], tag);
    sel_off;
  endtask

  task automatic set_mode(input logic [7:0] m);
    sel_on;
    put(8'h01);
    put(m);
    sel_off;
  endtask

  task automatic read_mode(input logic [7:0] expv, input string tag);
    sel_on;
    put(8'h05);
    expect_byte(expv, tag);
    sel_off;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog got=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);

    // R10: quiet output after reset
    check("R10 reset miso", {7'd0, miso}, 8'h00);
    // R3: mode register reset value
    read_mode(8'h40, "R3 mode reset value");

    // R1 R2 sequential write and read back
    mem_write(24'h000010, 32'hA1B2C3D4, 4);
    mem_read(24'h000010, 32'hA1B2C3D4, 4, "R1 R2 write/read");
    check("R10 miso after read", {7'd0, miso}, 8'h00);
    // R1: upper address bits ignored
    mem_read(24'h123410, 32'hA1000000, 1, "R1 alias");

    // R7: array wrap in sequential mode
    mem_write(24'h0000FF, 32'h5A6B0000, 2);
    mem_read(24'h000000, 32'h6B000000, 1, "R7 wrap write");
    mem_read(24'h0000FF, 32'h5A6B0000, 2, "R7 wrap read");

    // R6: page mode
    set_mode(8'h80);
    read_mode(8'h80, "R3 R4 page mode readback");
    mem_write(24'h00003E, 32'h11223300, 3);
    mem_read(24'h000020, 32'h33000000, 1, "R6 page wrap write");
    mem_read(24'h00003F, 32'h22330000, 2, "R6 page wrap read");

    // R5: byte mode
    set_mode(8'h40);
    mem_write(24'h000050, 32'h01990000, 2);
    set_mode(8'h00);
    mem_write(24'h000050, 32'h77880000, 2);
    mem_read(24'h000050, 32'h77000000, 2, "R5 byte mode read");
    set_mode(8'h40);
    mem_read(24'h000050, 32'h77990000, 2, "R5 byte mode write");

    // R4: reserved code 11 acts as byte mode
    set_mode(8'hC0);
    mem_write(24'h000050, 32'h55660000, 2);
    set_mode(8'h40);
    mem_read(24'h000050, 32'h55990000, 2, "R4 code 11 single byte");

    // R8: partial data byte is not written
    mem_write(24'h000070, 32'hE13C0000, 2);
    sel_on;
    put(8'h02);
    send_addr(24'h000070);
    put(8'hF0);
    xfer(8'h0F, rx, 5);
    sel_off;
    mem_read(24'h000070, 32'hF03C0000, 2, "R8 partial byte dropped");
    // R8: partial opcode leaves decoder idle for the next selection
    sel_on;
    xfer(8'h01, rx, 3);
    sel_off;
    read_mode(8'h40, "R8 partial opcode");

    // R9: ignored opcodes, including the two- and four-wire ones
    for (int k = 0; k < 4; k++) begin
      logic [7:0] op;
      op = (k == 0) ? 8'h3B : (k == 1) ? 8'h38 : (k == 2) ? 8'hFF : 8'hA5;
      sel_on;
      put(op);
      for (int j = 0; j < 5; j++) begin
        logic [7:0] b;
        b = (j == 0) ? 8'h02 : (j == 3) ? 8'h10 : (j == 4) ? 8'hEE : 8'h00;
        xfer(b, rx, 8);
        check("R9 miso quiet after ignored opcode", rx, 8'h00);
      end
      sel_off;
    end
    mem_read(24'h000010, 32'hA1000000, 1, "R9 array untouched");
    read_mode(8'h40, "R9 mode untouched");

    check("R10 miso deselected", {7'd0, miso}, 8'h00);

    wait_clk(10);
    if (got_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL scoreboard got=%0d left expected=0", got_q.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule